// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block chooses, for each of the two ALU inputs of a five-stage in-order integer pipeline, where the operand comes from. It looks at the source register numbers of the instruction now entering the execute stage. It compares them with the destination numbers held in the execute/memory and memory/writeback pipeline registers. From that comparison it produces a 2-bit select per operand and applies the select to a three-way operand multiplexer. The result is that an instruction sees a value produced one or two instructions earlier before that value has reached the register file.

Which sources are compared depends on a class code that comes with the instruction. Register-register operations and branches use both sources. Loads, stores and immediate operations use only the first source. When both later stages hold a matching write, the younger stage (execute/memory) wins. A dependence three instructions apart is not handled here: the register file writes in the first half of the cycle and reads in the second half, so its read port already returns the new value.

The unit is purely combinational and has no clock. It carries no data stream of its own and has no back-pressure, so every pin is a plain level signal that the surrounding pipeline registers drive and sample.

Top module: `fwd_unit_top`

## Requirements
- R1: When no enabled source matches an eligible producer, the select is 00 and the operand equals the register-file value for that source.
- R2: When a used source equals the execute/memory destination, that stage's write flag is 1 and the destination is nonzero, the select is 10 and the operand equals the execute/memory ALU result.
- R3: When a used source equals the memory/writeback destination, that stage's write flag is 1, the destination is nonzero and R2 does not apply, the select is 01 and the operand equals the memory/writeback value.
- R4: When both stages match the same source under R2 and R3, the select is 10 and the execute/memory value is used.
- R5: A stage whose write flag is 0 never causes a forward, whatever its destination number.
- R6: A destination of register 0 never causes a forward, even with its write flag at 1.
- R7: Class codes 0 (register-register) and 4 (branch) check both sources. Codes 1 (immediate), 2 (load) and 3 (store) check only source A, and for these codes the select for operand B is 00.
- R8: Class codes 5, 6 and 7 are undefined. They check neither source, and both selects are 00.
- R9: A select never takes the value 11.
- R10: Across any instruction sequence, each operand that the class uses equals the value of its source register in program order. That value is the result of the youngest earlier instruction that writes the register, or the register-file value if no such instruction exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_class | input | 3 | Class code of the instruction entering execute |
| ex_src_a | input | REG_AW | First source register number |
| ex_src_b | input | REG_AW | Second source register number |
| exm_dst | input | REG_AW | Destination number held in execute/memory |
| exm_wr | input | 1 | Register-write flag of execute/memory |
| mwb_dst | input | REG_AW | Destination number held in memory/writeback |
| mwb_wr | input | 1 | Register-write flag of memory/writeback |
| rf_data_a | input | DATA_W | Register-file read value for source A |
| rf_data_b | input | DATA_W | Register-file read value for source B |
| exm_result | input | DATA_W | ALU result held in execute/memory |
| mwb_result | input | DATA_W | Write-back value held in memory/writeback |
| sel_a | output | 2 | Operand A select: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B select, same encoding |
| opnd_a | output | DATA_W | Operand delivered to ALU input A |
| opnd_b | output | DATA_W | Operand delivered to ALU input B |

## Verification
The embedded checks assume that the inputs are settled values and that the register-file reads are write-first for the instruction three ahead. They also assume that the class code and the write flags are two-state. The directed tasks change one input group at a time and let it settle before sampling. The sequence task builds register-file, execute/memory and memory/writeback inputs from a bench-side program-order model, so the pipeline view it presents is always consistent with a real in-order machine. Register numbers are drawn from a small range, which makes back-to-back dependences and the same-register case in both stages frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source select, decoded by the operand multiplexer
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } opnd_sel_e;

  // Instruction class code entering execute
  typedef enum logic [2:0] {
    CLS_REGREG = 3'd0,
    CLS_IMM    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4
  } instr_cls_e;

  localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/fwd_class_decode.sv
module fwd_class_decode
  import fwd_pkg::*;
#(
  parameter int unsigned NOPND = NUM_OPND
) (
  input  logic [2:0]       cls,
  output logic [NOPND-1:0] use_src
);

  always_comb begin
    use_src = '0;
    case (cls)
      CLS_REGREG, CLS_BRANCH: use_src = '1;
      CLS_IMM, CLS_LOAD, CLS_STORE: use_src[0] = 1'b1;
      default: use_src = '0;
    endcase
  end

endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              used,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic              exm_wr,
  input  logic [REG_AW-1:0] mwb_dst,
  input  logic              mwb_wr,
  output opnd_sel_e         sel
);

  logic hit_exm, hit_mwb;

  always_comb begin
    hit_exm = used && exm_wr && (exm_dst != '0) && (exm_dst == src);
    hit_mwb = used && mwb_wr && (mwb_dst != '0) && (mwb_dst == src);
    if (hit_exm)      sel = SEL_EXMEM;
    else if (hit_mwb) sel = SEL_MEMWB;
    else              sel = SEL_RF;
  end

  // Younger producer must win when both stages match
  always_comb begin
    AST_YOUNGER_WINS: assert (!(hit_exm && hit_mwb) || sel == SEL_EXMEM)
      else $error("older stage chosen over younger"); // R4
  end

endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  opnd_sel_e         sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] mwb_val,
  output logic [DATA_W-1:0] opnd
);

  always_comb begin
    case (sel)
      SEL_EXMEM: opnd = exm_val;
      SEL_MEMWB: opnd = mwb_val;
      default:   opnd = rf_val;
    endcase
  end

  always_comb begin
    AST_SEL_LEGAL: assert (sel != 2'b11)
      else $error("illegal operand select"); // R9
  end

endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [2:0]        ex_class,
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic              exm_wr,
  input  logic [REG_AW-1:0] mwb_dst,
  input  logic              mwb_wr,
  input  logic [DATA_W-1:0] rf_data_a,
  input  logic [DATA_W-1:0] rf_data_b,
  input  logic [DATA_W-1:0] exm_result,
  input  logic [DATA_W-1:0] mwb_result,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int unsigned NOPND = NUM_OPND;

  logic [NOPND-1:0]             use_src;
  logic [NOPND-1:0][REG_AW-1:0] src_v;
  logic [NOPND-1:0][DATA_W-1:0] rf_v;
  logic [NOPND-1:0][DATA_W-1:0] opnd_v;
  opnd_sel_e                    sel_v [NOPND];

  assign src_v[0] = ex_src_a;
  assign src_v[1] = ex_src_b;
  assign rf_v[0]  = rf_data_a;
  assign rf_v[1]  = rf_data_b;

  fwd_class_decode #(.NOPND(NOPND)) u_decode (
    .cls     (ex_class),
    .use_src (use_src)
  );

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    fwd_src_pick #(.REG_AW(REG_AW)) u_pick (
      .used    (use_src[g]),
      .src     (src_v[g]),
      .exm_dst (exm_dst),
      .exm_wr  (exm_wr),
      .mwb_dst (mwb_dst),
      .mwb_wr  (mwb_wr),
      .sel     (sel_v[g])
    );

    fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sel_v[g]),
      .rf_val  (rf_v[g]),
      .exm_val (exm_result),
      .mwb_val (mwb_result),
      .opnd    (opnd_v[g])
    );

    always_comb begin
      AST_ZERO_REG_NO_FWD: assert (src_v[g] != '0 || sel_v[g] == SEL_RF)
        else $error("register 0 forwarded"); // R6
      AST_IDLE_STAGES_NO_FWD: assert (exm_wr || mwb_wr || sel_v[g] == SEL_RF)
        else $error("forward with no writing stage"); // R5
      AST_EXM_VALUE: assert (sel_v[g] != SEL_EXMEM || opnd_v[g] == exm_result)
        else $error("execute/memory operand mismatch"); // R2
      AST_MWB_VALUE: assert (sel_v[g] != SEL_MEMWB || opnd_v[g] == mwb_result)
        else $error("memory/writeback operand mismatch"); // R3
    end
  end

  assign sel_a  = sel_v[0];
  assign sel_b  = sel_v[1];
  assign opnd_a = opnd_v[0];
  assign opnd_b = opnd_v[1];

  always_comb begin
    AST_SINGLE_SRC_B_IDLE: assert (!(ex_class inside {3'd1, 3'd2, 3'd3}) || sel_b == 2'b00)
      else $error("operand B forwarded for single-source class"); // R7
    AST_UNDEF_CLASS_IDLE: assert (ex_class < 3'd5 || (sel_a == 2'b00 && sel_b == 2'b00))
      else $error("forward for undefined class"); // R8
  end

endmodule

// File: tb/test_fwd_unit_top.sv
module test_fwd_unit_top;

  localparam int unsigned REG_AW = 5;
  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] RF_A = 32'hA0A0_0001;
  localparam logic [31:0] RF_B = 32'hB0B0_0002;
  localparam logic [31:0] EXV  = 32'hE1E1_0003;
  localparam logic [31:0] MWV  = 32'h3C3C_0004;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [2:0]        ex_class;
  logic [REG_AW-1:0] ex_src_a, ex_src_b, exm_dst, mwb_dst;
  logic              exm_wr, mwb_wr;
  logic [DATA_W-1:0] rf_data_a, rf_data_b, exm_result, mwb_result;
  logic [1:0]        sel_a, sel_b;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  fwd_unit_top #(.REG_AW(REG_AW), .DATA_W(DATA_W)) i_fwd_unit_top (
    .ex_class, .ex_src_a, .ex_src_b, .exm_dst, .exm_wr, .mwb_dst, .mwb_wr,
    .rf_data_a, .rf_data_b, .exm_result, .mwb_result,
    .sel_a, .sel_b, .opnd_a, .opnd_b
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one settled pipeline view with fixed data words, then sample mid-cycle
  task automatic drive(input logic [2:0] cls, input int sa, input int sb,
                       input int ed, input logic ew, input int md, input logic mw);
    @(negedge clk);
    ex_class = cls; ex_src_a = REG_AW'(sa); ex_src_b = REG_AW'(sb);
    exm_dst = REG_AW'(ed); exm_wr = ew; mwb_dst = REG_AW'(md); mwb_wr = mw;
    rf_data_a = RF_A; rf_data_b = RF_B; exm_result = EXV; mwb_result = MWV;
    #2;
  endtask

  task automatic t_reset_state();
    drive(3'd0, 0, 0, 0, 1'b0, 0, 1'b0);
    chk("R1 idle sel_a", 32'(sel_a), 32'd0);
    chk("R1 idle sel_b", 32'(sel_b), 32'd0);
    chk("R1 idle opnd_a", opnd_a, RF_A);
    drive(3'd0, 3, 4, 5, 1'b1, 6, 1'b1);
    chk("R1 no match opnd_b", opnd_b, RF_B);
  endtask

  task automatic t_exm_fwd();
    drive(3'd0, 7, 2, 7, 1'b1, 9, 1'b1);
    chk("R2 sel_a from exm", 32'(sel_a), 32'd2);
    chk("R2 opnd_a", opnd_a, EXV);
    drive(3'd0, 2, 7, 7, 1'b1, 9, 1'b1);
    chk("R2 opnd_b", opnd_b, EXV);
  endtask

  task automatic t_mwb_fwd();
    drive(3'd0, 9, 1, 7, 1'b1, 9, 1'b1);
    chk("R3 sel_a from mwb", 32'(sel_a), 32'd1);
    chk("R3 opnd_a", opnd_a, MWV);
    drive(3'd4, 1, 9, 7, 1'b1, 9, 1'b1);
    chk("R3 branch opnd_b", opnd_b, MWV);
  endtask

  task automatic t_priority();
    drive(3'd0, 12, 12, 12, 1'b1, 12, 1'b1);
    chk("R4 sel_a younger", 32'(sel_a), 32'd2);
    chk("R4 opnd_b younger", opnd_b, EXV);
    drive(3'd0, 12, 3, 12, 1'b0, 12, 1'b1);
    chk("R4 falls to mwb when exm not writing", opnd_a, MWV);
  endtask

  task automatic t_write_flag();
    drive(3'd0, 8, 8, 8, 1'b0, 8, 1'b0);
    chk("R5 no write sel_a", 32'(sel_a), 32'd0);
    chk("R5 no write opnd_b", opnd_b, RF_B);
  endtask

  task automatic t_zero_reg();
    drive(3'd0, 0, 0, 0, 1'b1, 0, 1'b1);
    chk("R6 r0 sel_a", 32'(sel_a), 32'd0);
    chk("R6 r0 opnd_b", opnd_b, RF_B);
  endtask

  task automatic t_class_filter();
    for (int c = 1; c <= 3; c++) begin
      drive(3'(c), 5, 5, 5, 1'b1, 0, 1'b0);
      chk("R7 single-src A forwards", opnd_a, EXV);
      chk("R7 single-src B ignored", 32'(sel_b), 32'd0);
    end
    drive(3'd4, 5, 6, 5, 1'b1, 6, 1'b1);
    chk("R7 branch both a", 32'(sel_a), 32'd2);
    chk("R7 branch both b", 32'(sel_b), 32'd1);
  endtask

  task automatic t_undef_class();
    for (int c = 5; c <= 7; c++) begin
      drive(3'(c), 5, 6, 5, 1'b1, 6, 1'b1);
      chk("R8 undefined a", opnd_a, RF_A);
      chk("R8 undefined b", opnd_b, RF_B);
    end
  endtask

  // Program-order reference: a short random program through a bench-side pipeline view
  task automatic t_sequence();
    logic [31:0] arch [32];
    logic [31:0] rfv  [32];
    logic [4:0]  h_dst [3];
    logic        h_wr  [3];
    logic [31:0] h_res [3];
    for (int r = 0; r < 32; r++) begin arch[r] = 32'h100 * r; rfv[r] = 32'h100 * r; end
    for (int k = 0; k < 3; k++) begin h_dst[k] = '0; h_wr[k] = 1'b0; h_res[k] = '0; end
    for (int i = 0; i < 400; i++) begin
      logic [2:0]  cls;
      logic [4:0]  sa, sb, dd;
      logic        we, useb;
      logic [31:0] ea, eb, res;
      cls = 3'($urandom_range(0, 4));
      sa  = 5'($urandom_range(0, 3));
      sb  = 5'($urandom_range(0, 3));
      dd  = 5'($urandom_range(0, 3));
      we  = (cls != 3'd3) && (cls != 3'd4);
      useb = (cls == 3'd0) || (cls == 3'd4);
      // register file holds writes of instructions up to i-3 (write-first read)
      if (h_wr[2] && h_dst[2] != 0) rfv[h_dst[2]] = h_res[2];
      @(negedge clk);
      ex_class = cls; ex_src_a = sa; ex_src_b = sb;
      exm_dst = h_dst[0]; exm_wr = h_wr[0]; exm_result = h_res[0];
      mwb_dst = h_dst[1]; mwb_wr = h_wr[1]; mwb_result = h_res[1];
      rf_data_a = rfv[sa]; rf_data_b = rfv[sb];
      #2;
      ea = arch[sa];
      eb = useb ? arch[sb] : rfv[sb];
      chk("R10 sequence operand A", opnd_a, ea);
      chk("R10 sequence operand B", opnd_b, eb);
      res = (ea ^ {eb[15:0], eb[31:16]}) + 32'(i) + 32'h1;
      if (we && dd != 0) arch[dd] = res;
      h_dst[2] = h_dst[1]; h_wr[2] = h_wr[1]; h_res[2] = h_res[1];
      h_dst[1] = h_dst[0]; h_wr[1] = h_wr[0]; h_res[1] = h_res[0];
      h_dst[0] = dd;       h_wr[0] = we;      h_res[0] = res;
    end
  endtask

  initial begin
    t_reset_state();
    t_exm_fwd();
    t_mwb_fwd();
    t_priority();
    t_write_flag();
    t_zero_reg();
    t_class_filter();
    t_undef_class();
    t_sequence();
    done = 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      done = 1;
    end
  end

  initial begin
    wait (done);
    #1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule